// File: doc/BRIEF.md
# On-chip RAM window decoder

This block sits between a 16-bit processor bus and a small on-chip RAM, which it contains. For every bus request it decides in the request cycle whether the access belongs to the internal RAM, to the off-chip bus controller, or is an illegal access. A single enable bit, readable and writable through a one-bit control port, switches the RAM window on or off. The position of the window depends on whether the system runs with a 20-bit or a 24-bit address space. The window always ends 0xE0 bytes below the top of the active address space and spans `RAM_BYTES` bytes below that point. A smaller RAM variant is obtained by setting `RAM_BYTES` to 2048.

Internal RAM accesses take two bus states. The request cycle is the first state and the following cycle is the second, in which `ack` is raised and read data is valid. Byte data always travels on the upper lane of the data bus. A word is made of the byte at the even address, on the upper lane, followed by the byte at the next odd address, on the lower lane.

The enable bit is set by the hardware reset and by nothing else. A standby input freezes the block without touching that bit.

Top module: `ram_window_dec`

## Requirements
- R1: While `rst` is high on a clock edge the enable bit becomes 1, so `ctl_rbit` reads 1 after reset, including a reset that follows a software clear.
- R2: With `standby` low, a clock edge with `ctl_we` high loads `ctl_wbit` into the enable bit, which `ctl_rbit` shows from the next cycle.
- R3: While `standby` is high, the enable bit keeps its value, `ctl_we` is ignored, and `req` raises none of `ram_cs`, `ext_sel`, `addr_err`. Entering or leaving standby leaves the enable bit unchanged.
- R4: With `addr_wide` = 0, only `addr[19:0]` is decoded and the RAM window is 0xFEF20 to 0xFFF1F. Inside it, with the enable bit at 1, `ram_cs` is high and `ext_sel` low in the request cycle.
- R5: With `addr_wide` = 1, all 24 address bits are decoded and the RAM window is 0xFFEF20 to 0xFFFF1F, with the same select behaviour as R4.
- R6: A request outside the window, or inside it while the enable bit is 0, raises `ext_sel` in the request cycle and leaves `ram_cs` and `ack` low. `ram_cs` and `ext_sel` are never high together.
- R7: An internal RAM access holds `ram_cs` high in the request cycle and in the next cycle. `ack` is high in that second cycle only. A `req` presented in that second cycle is ignored.
- R8: A byte write stores `wdata[15:8]`. A byte read returns the byte on `rdata[15:8]` with `rdata[7:0]` = 0. The byte at an even offset is the upper half of its word.
- R9: A word access at an even address moves all 16 bits. `rdata[15:8]`/`wdata[15:8]` carry the byte at the address and `[7:0]` the byte at address+1. `rdata` is valid while `ack` is high on a read.
- R10: A word request at an odd address that falls in the enabled window raises `addr_err` in the request cycle. It raises neither `ram_cs`, `ext_sel` nor `ack`, and leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| standby | input | 1 | Software standby: freezes requests and control writes |
| addr_wide | input | 1 | 1 = 24-bit address space, 0 = 20-bit address space |
| ctl_we | input | 1 | Write strobe for the enable bit |
| ctl_wbit | input | 1 | New value of the enable bit |
| ctl_rbit | output | 1 | Current value of the enable bit |
| req | input | 1 | Bus request, one cycle per access |
| addr | input | 24 | Byte address |
| wr | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = 16-bit access, 0 = byte access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with `ack` on reads, otherwise 0 |
| ram_cs | output | 1 | Internal RAM selected |
| ext_sel | output | 1 | Access handed to the off-chip bus controller |
| addr_err | output | 1 | Odd-address word access to the internal RAM |
| ack | output | 1 | Second state of an internal RAM access |

## Verification
The bench probes both ends of each window, and the addresses one byte beyond them, in both address modes. A decoder with an off-by-one bound would claim a foreign byte or hand a RAM byte to the external bus. In 20-bit mode it sets junk in the top address nibble, which a decoder that compares too many bits would send off chip. It writes bytes at even and odd offsets and reads them back both as a word and as bytes, exposing swapped or zero-filled lanes. It also sends an odd word write and then confirms that memory kept its old value. A request issued during the second state must produce no extra `ack` or external select. Toggling standby and reset around a cleared enable bit shows whether standby wrongly reinitialises the bit or reset fails to restore it.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;
    localparam int ADDR_W   = 24;
    localparam int NARROW_W = 20;
    localparam int DATA_W   = 16;
    localparam int LANE_W   = 8;
    localparam int LANES    = DATA_W / LANE_W;
    localparam int LANE_HI  = 1;
    localparam int LANE_LO  = 0;

    typedef enum logic [1:0] {
        ROUTE_NONE = 2'd0,
        ROUTE_RAM  = 2'd1,
        ROUTE_EXT  = 2'd2,
        ROUTE_ERR  = 2'd3
    } route_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              word;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [LANES-1:0] lane_mask(input logic word, input logic odd);
        if (word)     return {LANES{1'b1}};
        else if (odd) return LANES'(1) << LANE_LO;
        else          return LANES'(1) << LANE_HI;
    endfunction
endpackage

// File: rtl/ramwin_decode.sv
module ramwin_decode
    import ramwin_pkg::*;
#(
    parameter int RAM_BYTES = 4096,
    parameter int TOP_GAP   = 224,
    parameter int OFF_W     = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    input  logic              word,
    input  logic              en,
    output route_e            route,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [ADDR_W-1:0] TOP_WIDE   = {ADDR_W{1'b1}} - ADDR_W'(TOP_GAP);
    localparam logic [ADDR_W-1:0] TOP_NARROW =
        {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}} - ADDR_W'(TOP_GAP);
    localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(RAM_BYTES - 1);

    logic [ADDR_W-1:0] a_eff, top_a, base_a;
    logic              hit;

    always_comb begin
        a_eff  = wide ? addr : {{(ADDR_W-NARROW_W){1'b0}}, addr[NARROW_W-1:0]};
        top_a  = wide ? TOP_WIDE : TOP_NARROW;
        base_a = top_a - SPAN;
        hit    = (a_eff >= base_a) && (a_eff <= top_a);
        offset = a_eff[OFF_W-1:0] - base_a[OFF_W-1:0];
        if (!hit || !en)           route = ROUTE_EXT;
        else if (word && addr[0])  route = ROUTE_ERR;
        else                       route = ROUTE_RAM;
    end
endmodule

// File: rtl/ramwin_ctrl.sv
module ramwin_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic ctl_we,
    input  logic ctl_wbit,
    output logic ram_en
);
    always_ff @(posedge clk) begin
        if (rst)                     ram_en <= 1'b1;
        else if (ctl_we && !standby) ram_en <= ctl_wbit;
    end
endmodule

// File: rtl/ramwin_lane_mem.sv
module ramwin_lane_mem
    import ramwin_pkg::*;
#(
    parameter int DEPTH = 2048,
    parameter int IDX_W = 11
) (
    input  logic              clk,
    input  logic              acc,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_we,
    input  logic [LANE_W-1:0] wlane [LANES],
    output logic [LANE_W-1:0] rlane [LANES]
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[idx] <= wlane[g];
            if (acc)        rlane[g] <= mem[idx];
        end
    end
endmodule

// File: rtl/ramwin_seq.sv
module ramwin_seq
    import ramwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr,
    input  logic              word,
    input  logic              odd,
    input  logic [LANE_W-1:0] rlane [LANES],
    output logic              busy,
    output logic [DATA_W-1:0] rdata
);
    logic wr_q, word_q, odd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            wr_q   <= 1'b0;
            word_q <= 1'b0;
            odd_q  <= 1'b0;
        end else begin
            busy <= start;
            if (start) begin
                wr_q   <= wr;
                word_q <= word;
                odd_q  <= odd;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (busy && !wr_q) begin
            if (word_q)     rdata = {rlane[LANE_HI], rlane[LANE_LO]};
            else if (odd_q) rdata = {rlane[LANE_LO], {LANE_W{1'b0}}};
            else            rdata = {rlane[LANE_HI], {LANE_W{1'b0}}};
        end
    end
endmodule

// File: rtl/ram_window_dec.sv
module ram_window_dec
    import ramwin_pkg::*;
#(
    parameter int RAM_BYTES = 4096,
    parameter int TOP_GAP   = 224
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              addr_wide,
    input  logic              ctl_we,
    input  logic              ctl_wbit,
    output logic              ctl_rbit,
    input  logic              req,
    input  logic [23:0]       addr,
    input  logic              wr,
    input  logic              word,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              ram_cs,
    output logic              ext_sel,
    output logic              addr_err,
    output logic              ack
);
    localparam int OFF_W = $clog2(RAM_BYTES);
    localparam int DEPTH = RAM_BYTES / LANES;
    localparam int IDX_W = OFF_W - 1;

    bus_req_t          breq;
    route_e            route;
    logic [OFF_W-1:0]  offset;
    logic              ram_en, busy, accept, ram_go;
    logic [LANES-1:0]  lane_we;
    logic [LANE_W-1:0] wlane [LANES];
    logic [LANE_W-1:0] rlane [LANES];

    assign breq = '{addr: addr, wr: wr, word: word, wdata: wdata};

    ramwin_ctrl u_ctrl (
        .clk(clk), .rst(rst), .standby(standby),
        .ctl_we(ctl_we), .ctl_wbit(ctl_wbit), .ram_en(ram_en)
    );

    ramwin_decode #(.RAM_BYTES(RAM_BYTES), .TOP_GAP(TOP_GAP), .OFF_W(OFF_W)) u_dec (
        .addr(breq.addr), .wide(addr_wide), .word(breq.word), .en(ram_en),
        .route(route), .offset(offset)
    );

    always_comb begin
        accept   = req && !standby && !busy;
        ram_go   = accept && (route == ROUTE_RAM);
        ext_sel  = accept && (route == ROUTE_EXT);
        addr_err = accept && (route == ROUTE_ERR);
        ram_cs   = ram_go || busy;
        lane_we  = (ram_go && breq.wr) ? lane_mask(breq.word, offset[0]) : '0;
        wlane[LANE_HI] = breq.wdata[DATA_W-1 -: LANE_W];
        wlane[LANE_LO] = breq.word ? breq.wdata[LANE_W-1:0] : breq.wdata[DATA_W-1 -: LANE_W];
    end

    ramwin_lane_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .acc(ram_go), .idx(offset[OFF_W-1:1]),
        .lane_we(lane_we), .wlane(wlane), .rlane(rlane)
    );

    ramwin_seq u_seq (
        .clk(clk), .rst(rst), .start(ram_go), .wr(breq.wr), .word(breq.word),
        .odd(offset[0]), .rlane(rlane), .busy(busy), .rdata(rdata)
    );

    assign ack      = busy;
    assign ctl_rbit = ram_en;
endmodule

// File: rtl/ramwin_chk.sv
module ramwin_chk (
    input logic clk,
    input logic rst,
    input logic standby,
    input logic ctl_rbit,
    input logic ram_cs,
    input logic ext_sel,
    input logic addr_err,
    input logic ack
);
    assert_reset_en_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctl_rbit);

    assert_standby_hold_R3: assert property (@(posedge clk) disable iff (rst)
        standby |=> $stable(ctl_rbit));

    assert_sel_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(ram_cs && ext_sel));

    assert_two_state_R7: assert property (@(posedge clk) disable iff (rst)
        (ram_cs && !ack) |=> (ack && ram_cs));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_err_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> (!ram_cs && !ext_sel && !ack));
endmodule

bind ram_window_dec ramwin_chk u_chk (
    .clk(clk), .rst(rst), .standby(standby), .ctl_rbit(ctl_rbit),
    .ram_cs(ram_cs), .ext_sel(ext_sel), .addr_err(addr_err), .ack(ack)
);

// File: tb/sim_ram_window_dec.sv
module sim_ram_window_dec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby = 1'b0, addr_wide = 1'b1;
    logic        ctl_we = 1'b0, ctl_wbit = 1'b0;
    logic        ctl_rbit;
    logic        req = 1'b0, wr = 1'b0, word = 1'b0;
    logic [23:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ram_cs, ext_sel, addr_err, ack;

    int n_chk = 0, n_fail = 0;
    logic        s_cs1, s_ext1, s_err1, s_ack2, s_cs2;
    logic [15:0] s_rd2;

    always #4 clk = ~clk;

    ram_window_dec u0 (
        .clk(clk), .rst(rst), .standby(standby), .addr_wide(addr_wide),
        .ctl_we(ctl_we), .ctl_wbit(ctl_wbit), .ctl_rbit(ctl_rbit),
        .req(req), .addr(addr), .wr(wr), .word(word), .wdata(wdata),
        .rdata(rdata), .ram_cs(ram_cs), .ext_sel(ext_sel),
        .addr_err(addr_err), .ack(ack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic w, input logic wd, input logic [15:0] d);
        @(negedge clk);
        req = 1'b1; addr = a; wr = w; word = wd; wdata = d;
        #1;
        s_cs1 = ram_cs; s_ext1 = ext_sel; s_err1 = addr_err;
        @(negedge clk);
        req = 1'b0; wr = 1'b0; word = 1'b0;
        #1;
        s_ack2 = ack; s_cs2 = ram_cs; s_rd2 = rdata;
    endtask

    task automatic ctl_write(input logic b);
        @(negedge clk); ctl_we = 1'b1; ctl_wbit = b;
        @(negedge clk); ctl_we = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 enable after reset", ctl_rbit, 1);
        chk("R1 no select idle", {ram_cs, ext_sel, addr_err, ack}, 0);
    endtask

    task automatic t_ctl;
        ctl_write(1'b0);
        chk("R2 enable cleared", ctl_rbit, 0);
        ctl_write(1'b1);
        chk("R2 enable set", ctl_rbit, 1);
        ctl_write(1'b0);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset restores enable", ctl_rbit, 1);
    endtask

    task automatic t_standby;
        @(negedge clk); standby = 1'b1; #1;
        chk("R3 enable on standby entry", ctl_rbit, 1);
        ctl_write(1'b0);
        chk("R3 ctl write ignored", ctl_rbit, 1);
        access(24'hFFEF20, 1'b0, 1'b0, 16'h0);
        chk("R3 request ignored", {s_cs1, s_ext1, s_err1, s_ack2}, 0);
        @(negedge clk); standby = 1'b0; #1;
        chk("R3 enable after exit", ctl_rbit, 1);
        ctl_write(1'b0);
        @(negedge clk); standby = 1'b1;
        @(negedge clk); standby = 1'b0; #1;
        chk("R3 cleared bit survives standby", ctl_rbit, 0);
        ctl_write(1'b1);
    endtask

    task automatic t_window20;
        addr_wide = 1'b0;
        access(24'h0FEF20, 1'b1, 1'b0, 16'h5A00);
        chk("R4 base selects ram", {s_cs1, s_ext1, s_ack2}, 3'b101);
        access(24'h0FFF1F, 1'b0, 1'b0, 16'h0);
        chk("R4 top selects ram", {s_cs1, s_ext1}, 2'b10);
        access(24'h0FEF1F, 1'b0, 1'b0, 16'h0);
        chk("R4 below base external", {s_cs1, s_ext1, s_ack2}, 3'b010);
        access(24'h0FFF20, 1'b0, 1'b0, 16'h0);
        chk("R4 above top external", {s_cs1, s_ext1, s_ack2}, 3'b010);
        access(24'hAFEF20, 1'b0, 1'b0, 16'h0);
        chk("R4 upper nibble ignored", {s_cs1, s_ext1}, 2'b10);
        chk("R4 data at base", s_rd2, 16'h5A00);
        addr_wide = 1'b1;
        access(24'hFFEF20, 1'b0, 1'b0, 16'h0);
        chk("R5 same cell in wide mode", s_rd2, 16'h5A00);
    endtask

    task automatic t_window24;
        addr_wide = 1'b1;
        access(24'hFFEF20, 1'b0, 1'b0, 16'h0);
        chk("R5 base selects ram", {s_cs1, s_ext1, s_cs2, s_ack2}, 4'b1011);
        access(24'hFFFF1F, 1'b0, 1'b0, 16'h0);
        chk("R5 top selects ram", {s_cs1, s_ext1}, 2'b10);
        access(24'hFFEF1F, 1'b0, 1'b0, 16'h0);
        chk("R5 below base external", {s_cs1, s_ext1}, 2'b01);
        access(24'hFFFF20, 1'b0, 1'b0, 16'h0);
        chk("R5 above top external", {s_cs1, s_ext1}, 2'b01);
        access(24'h0FEF20, 1'b0, 1'b0, 16'h0);
        chk("R5 narrow window not ram", {s_cs1, s_ext1}, 2'b01);
    endtask

    task automatic t_disabled;
        ctl_write(1'b0);
        access(24'hFFEF20, 1'b0, 1'b0, 16'h0);
        chk("R6 disabled goes external", {s_cs1, s_ext1, s_err1, s_ack2}, 4'b0100);
        access(24'hFFEF21, 1'b0, 1'b1, 16'h0);
        chk("R6 disabled odd word external", {s_cs1, s_ext1, s_err1}, 3'b010);
        ctl_write(1'b1);
    endtask

    task automatic t_lanes;
        access(24'hFFF000, 1'b1, 1'b0, 16'hA511);
        access(24'hFFF001, 1'b1, 1'b0, 16'h3C22);
        access(24'hFFF000, 1'b0, 1'b1, 16'h0);
        chk("R8 bytes assemble into word", s_rd2, 16'hA53C);
        access(24'hFFF001, 1'b0, 1'b0, 16'h0);
        chk("R8 odd byte on upper lane", s_rd2, 16'h3C00);
        access(24'hFFF000, 1'b0, 1'b0, 16'h0);
        chk("R8 even byte on upper lane", s_rd2, 16'hA500);
    endtask

    task automatic t_word;
        access(24'hFFEF40, 1'b1, 1'b1, 16'h1234);
        access(24'hFFEF40, 1'b0, 1'b0, 16'h0);
        chk("R9 high byte at even addr", s_rd2, 16'h1200);
        access(24'hFFEF41, 1'b0, 1'b0, 16'h0);
        chk("R9 low byte at odd addr", s_rd2, 16'h3400);
        access(24'hFFFF1E, 1'b1, 1'b1, 16'hBEEF);
        access(24'hFFFF1E, 1'b0, 1'b1, 16'h0);
        chk("R9 top word readback", s_rd2, 16'hBEEF);
        chk("R9 ack on read", s_ack2, 1);
    endtask

    task automatic t_odd;
        access(24'hFFEF41, 1'b1, 1'b1, 16'hFFFF);
        chk("R10 odd word flagged", {s_err1, s_cs1, s_ext1, s_ack2}, 4'b1000);
        access(24'hFFEF40, 1'b0, 1'b1, 16'h0);
        chk("R10 memory untouched", s_rd2, 16'h1234);
    endtask

    task automatic t_busy;
        @(negedge clk);
        req = 1'b1; addr = 24'hFFEF40; wr = 1'b0; word = 1'b1;
        @(negedge clk);
        addr = 24'h000100; #1;
        chk("R7 second state ack", {ack, ram_cs, ext_sel}, 3'b110);
        chk("R7 read data in second state", rdata, 16'h1234);
        @(negedge clk);
        req = 1'b0; word = 1'b0; #1;
        chk("R7 request in second state ignored", {ack, ram_cs, ext_sel}, 3'b000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_ctl();
        t_standby();
        t_window24();
        t_window20();
        t_disabled();
        t_lanes();
        t_word();
        t_odd();
        t_busy();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule